// File: doc/BRIEF.md
# System Control Register Bank with Variant-Selected Map

This block is a bank of memory-mapped system control registers on a simple synchronous register bus. The bus carries a write strobe, a word address and write data. Read data follows the address without a clock, and a one-cycle error pulse reports a write that the bank refused. The bank stores reset-cause and reset-mask words, a retention word and boot vectors, and it also holds a CPU-wait control, secure-debug control bits, clock divider and force words, a power control word and power-domain sense words. It can raise a single-cycle software reset request. The bank only stores these words and drives them onto its outputs. Clock division, power sequencing and debug enforcement are done by the logic that consumes those outputs.

A compile-time parameter `VARIANT` (0, 1 or 2) chooses the address map. It decides which offsets exist and what some offsets mean. Variant 2 adds a lock bit on boot vector 0 and a power control word that can lock itself. On variant 2 the CPU-wait control also moves to a different offset. Two resets are used. `rst_n` is the asynchronous power-on reset and clears everything. `warm_rst_n` is a synchronous warm reset, normally driven by the system after a software reset request, and it clears everything except the retention word.

Top module: `sysctl_bank`

## Requirements
- R1: Address map (word offsets): 0 reset cause, 1 reset mask, 2 retention, 3 boot vector 0, 6 debug set, 7 debug clear, 8 software reset, 18 debug status, 20 to 23 identification. Offset 4 is CPU wait on variants 0 and 1 and is unmapped on variant 2. Offset 5 is wake control storage on variants 0 and 1 and is CPU wait on variant 2. Offsets 9, 10, 11 (two dividers, clock force) and 14 (system sense) exist on variants 1 and 2. Offset 12 (boot vector 1) and offset 16 (memory sense) exist only on variant 1. Offsets 13 (power control) and 15 (CPU sense) exist only on variant 2. Offset 17 (interrupt enable) is storage on variant 1, read-only on variant 0, and unmapped on variant 2. All other offsets are unmapped.
- R2: Every storage offset reads back the last value written to it.
- R3: The retention word at offset 2 is cleared by `rst_n` and keeps its value through `warm_rst_n`.
- R4: On variant 2, a write to offset 3 while its stored bit 0 (lock) is 1 is dropped and flagged as an error. On variants 0 and 1 every write to offset 3 stores the full word.
- R5: On variant 2, `boot_vec0` carries only bits 31 to 7 of offset 3, with bits 6 to 0 forced to zero. On variants 0 and 1 it carries the whole word. `boot_vec1` carries offset 12.
- R6: A write to offset 6 ORs the write data into the debug state. A write to offset 7 clears each debug bit where the write data is 1. The state appears on `dbg_ctrl` and reads at offset 18. Offsets 6 and 7 read as zero.
- R7: A write to offset 8 with bit 0 set raises `sw_rst_req` for the single following cycle. The other bits of offset 8 have no effect, and offset 8 reads as zero.
- R8: On variant 2, the power control word at offset 13 resets to 1. A write to it is stored only while the stored bit 0 (unlock) is 1. Otherwise the write is dropped and flagged.
- R9: `cpu_wait` carries the CPU-wait word from the offset chosen by the variant, as listed in R1.
- R10: A write to a read-only offset (18, 20 to 23, and 17 on variant 0) or to an unmapped offset is flagged and changes no state. Unmapped offsets read zero. Identification offset 20+i reads `ID_BASE`+i.
- R11: `werr` is high for exactly the one cycle after each faulting write and is low otherwise.
- R12: After either reset, all storage reads zero except these: boot vectors 0 and 1 reset to `BOOT_RST`, power control resets to 1, and the retention word is kept through a warm reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| warm_rst_n | input | 1 | Synchronous active-low warm reset; leaves the retention word alone |
| wr_en | input | 1 | Write strobe |
| addr | input | AW | Word offset |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr` (combinational) |
| werr | output | 1 | One-cycle pulse after a refused write |
| sw_rst_req | output | 1 | One-cycle software reset request |
| boot_vec0 | output | DW | Boot vector for CPU 0 |
| boot_vec1 | output | DW | Boot vector for CPU 1 |
| cpu_wait | output | DW | CPU-wait control word |
| dbg_ctrl | output | DW | Secure-debug control state |

## Verification
The hardest states to reach are the self-locking ones. On variant 2, once the power control word is written with its unlock bit clear, or boot vector 0 is written with its lock bit set, no further bus write can change it. Only a reset reopens it. The stimulus drives all three variants from the same bus, then locks both words, hammers them with writes, and applies a warm reset to show that it unlocks them while the retention word survives. It then locks them again during a long stretch of random writes, with the reference model tracking each variant's map.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [4:0] {
    SL_NONE, SL_RCAUSE, SL_RMASK, SL_RETAIN, SL_BOOT0, SL_CPUWAIT, SL_WAKE,
    SL_DBGSET, SL_DBGCLR, SL_SWRST, SL_FDIV, SL_SDIV, SL_CFORCE, SL_BOOT1,
    SL_PWR, SL_SNS_SYS, SL_SNS_CPU, SL_SNS_MEM, SL_IRQEN, SL_DBGSTAT, SL_IDENT
  } slot_e;

  // variant codes
  localparam int VAR_BASE = 0;
  localparam int VAR_MID  = 1;
  localparam int VAR_LOCK = 2;

  // word offsets
  localparam int OFS_RCAUSE  = 0;
  localparam int OFS_RMASK   = 1;
  localparam int OFS_RETAIN  = 2;
  localparam int OFS_BOOT0   = 3;
  localparam int OFS_WAITA   = 4;
  localparam int OFS_WAKE    = 5;
  localparam int OFS_DBGSET  = 6;
  localparam int OFS_DBGCLR  = 7;
  localparam int OFS_SWRST   = 8;
  localparam int OFS_FDIV    = 9;
  localparam int OFS_SDIV    = 10;
  localparam int OFS_CFORCE  = 11;
  localparam int OFS_BOOT1   = 12;
  localparam int OFS_PWR     = 13;
  localparam int OFS_SNS_SYS = 14;
  localparam int OFS_SNS_CPU = 15;
  localparam int OFS_SNS_MEM = 16;
  localparam int OFS_IRQEN   = 17;
  localparam int OFS_DBGSTAT = 18;
  localparam int OFS_ID_LO   = 20;
  localparam int OFS_ID_HI   = 23;

  // plain storage fields held in one generated array
  localparam int NPLAIN     = 13;
  localparam int PL_RETAIN  = 2;
  localparam int PL_CPUWAIT = 3;
  localparam int PL_BOOT1   = 8;

  function automatic int plain_index(slot_e s);
    case (s)
      SL_RCAUSE:  return 0;
      SL_RMASK:   return 1;
      SL_RETAIN:  return PL_RETAIN;
      SL_CPUWAIT: return PL_CPUWAIT;
      SL_WAKE:    return 4;
      SL_FDIV:    return 5;
      SL_SDIV:    return 6;
      SL_CFORCE:  return 7;
      SL_BOOT1:   return PL_BOOT1;
      SL_SNS_SYS: return 9;
      SL_SNS_CPU: return 10;
      SL_SNS_MEM: return 11;
      SL_IRQEN:   return 12;
      default:    return -1;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int AW      = 6,
  parameter int VARIANT = 2
) (
  input  logic [AW-1:0] addr,
  output slot_e         slot,
  output logic          is_ro
);

  localparam bit HAS_MID  = (VARIANT == VAR_MID);
  localparam bit HAS_LOCK = (VARIANT == VAR_LOCK);
  localparam bit IS_BASE  = (VARIANT == VAR_BASE);

  int a;

  always_comb begin
    a     = int'(addr);
    slot  = SL_NONE;
    is_ro = 1'b0;
    case (a)
      OFS_RCAUSE:  slot = SL_RCAUSE;
      OFS_RMASK:   slot = SL_RMASK;
      OFS_RETAIN:  slot = SL_RETAIN;
      OFS_BOOT0:   slot = SL_BOOT0;
      OFS_WAITA:   slot = HAS_LOCK ? SL_NONE : SL_CPUWAIT;
      OFS_WAKE:    slot = HAS_LOCK ? SL_CPUWAIT : SL_WAKE;
      OFS_DBGSET:  slot = SL_DBGSET;
      OFS_DBGCLR:  slot = SL_DBGCLR;
      OFS_SWRST:   slot = SL_SWRST;
      OFS_FDIV:    slot = IS_BASE ? SL_NONE : SL_FDIV;
      OFS_SDIV:    slot = IS_BASE ? SL_NONE : SL_SDIV;
      OFS_CFORCE:  slot = IS_BASE ? SL_NONE : SL_CFORCE;
      OFS_BOOT1:   slot = HAS_MID ? SL_BOOT1 : SL_NONE;
      OFS_PWR:     slot = HAS_LOCK ? SL_PWR : SL_NONE;
      OFS_SNS_SYS: slot = IS_BASE ? SL_NONE : SL_SNS_SYS;
      OFS_SNS_CPU: slot = HAS_LOCK ? SL_SNS_CPU : SL_NONE;
      OFS_SNS_MEM: slot = HAS_MID ? SL_SNS_MEM : SL_NONE;
      OFS_IRQEN: begin
        slot  = HAS_MID ? SL_IRQEN : SL_NONE;
        is_ro = IS_BASE;
      end
      OFS_DBGSTAT: begin
        slot  = SL_DBGSTAT;
        is_ro = 1'b1;
      end
      default: begin
        if (a >= OFS_ID_LO && a <= OFS_ID_HI) begin
          slot  = SL_IDENT;
          is_ro = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/sysctl_field.sv
module sysctl_field #(
  parameter int              DW      = 32,
  parameter logic [DW-1:0]   RST_VAL = '0,
  parameter bit              KEEP    = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm_rst_n,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (!warm_rst_n && !KEEP) begin
      q <= RST_VAL;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int            DW       = 32,
  parameter int            AW       = 6,
  parameter int            VARIANT  = 2,
  parameter logic [DW-1:0] BOOT_RST = 32'h1000_0000,
  parameter logic [DW-1:0] ID_BASE  = 32'h5C00_0000,
  parameter int            VEC_LSB  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm_rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          werr,
  output logic          sw_rst_req,
  output logic [DW-1:0] boot_vec0,
  output logic [DW-1:0] boot_vec1,
  output logic [DW-1:0] cpu_wait,
  output logic [DW-1:0] dbg_ctrl
);

  localparam bit            LOCKING  = (VARIANT == VAR_LOCK);
  localparam logic [DW-1:0] VEC_MASK = {DW{1'b1}} << VEC_LSB;
  localparam logic [DW-1:0] PWR_RST  = DW'(1);

  slot_e slot;
  logic  is_ro;

  sysctl_decode #(.AW(AW), .VARIANT(VARIANT)) u_dec (
    .addr  (addr),
    .slot  (slot),
    .is_ro (is_ro)
  );

  logic [DW-1:0] plain_q [NPLAIN];
  logic [DW-1:0] boot0_q, pwr_q, dbg_q;
  logic [DW-1:0] boot0_d, dbg_d;
  logic          boot0_en, pwr_en, dbg_en;
  logic          unmapped, boot0_drop, pwr_drop, fault;
  logic          werr_d, req_d, werr_q, req_q;
  int            pidx;

  // ---------------- next-state ----------------
  always_comb begin
    pidx       = plain_index(slot);
    unmapped   = (slot == SL_NONE) || is_ro;
    boot0_drop = LOCKING && (slot == SL_BOOT0) && boot0_q[0];
    pwr_drop   = (slot == SL_PWR) && !pwr_q[0];
    fault      = wr_en && (unmapped || boot0_drop || pwr_drop);

    boot0_en = wr_en && (slot == SL_BOOT0) && !boot0_drop;
    boot0_d  = wdata;
    pwr_en   = wr_en && (slot == SL_PWR) && !pwr_drop;
    dbg_en   = wr_en && ((slot == SL_DBGSET) || (slot == SL_DBGCLR));
    dbg_d    = (slot == SL_DBGSET) ? (dbg_q | wdata) : (dbg_q & ~wdata);

    werr_d = fault;
    req_d  = wr_en && (slot == SL_SWRST) && wdata[0];
  end

  // ---------------- storage ----------------
  for (genvar k = 0; k < NPLAIN; k++) begin : g_plain
    localparam logic [DW-1:0] RV = (k == PL_BOOT1) ? BOOT_RST : '0;
    logic en_k;
    assign en_k = wr_en && !unmapped && (pidx == k);
    sysctl_field #(.DW(DW), .RST_VAL(RV), .KEEP(k == PL_RETAIN)) u_fld (
      .clk        (clk),
      .rst_n      (rst_n),
      .warm_rst_n (warm_rst_n),
      .en         (en_k),
      .d          (wdata),
      .q          (plain_q[k])
    );
  end

  sysctl_field #(.DW(DW), .RST_VAL(BOOT_RST), .KEEP(1'b0)) u_boot0 (
    .clk (clk), .rst_n (rst_n), .warm_rst_n (warm_rst_n),
    .en (boot0_en), .d (boot0_d), .q (boot0_q)
  );

  sysctl_field #(.DW(DW), .RST_VAL(PWR_RST), .KEEP(1'b0)) u_pwr (
    .clk (clk), .rst_n (rst_n), .warm_rst_n (warm_rst_n),
    .en (pwr_en), .d (wdata), .q (pwr_q)
  );

  sysctl_field #(.DW(DW), .RST_VAL('0), .KEEP(1'b0)) u_dbg (
    .clk (clk), .rst_n (rst_n), .warm_rst_n (warm_rst_n),
    .en (dbg_en), .d (dbg_d), .q (dbg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      werr_q <= 1'b0;
      req_q  <= 1'b0;
    end else if (!warm_rst_n) begin
      werr_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      werr_q <= werr_d;
      req_q  <= req_d;
    end
  end

  // ---------------- read mux and outputs ----------------
  always_comb begin
    rdata = '0;
    for (int k = 0; k < NPLAIN; k++) begin
      if (!unmapped && pidx == k) rdata = plain_q[k];
    end
    case (slot)
      SL_BOOT0:   rdata = boot0_q;
      SL_PWR:     rdata = pwr_q;
      SL_DBGSTAT: rdata = dbg_q;
      SL_IDENT:   rdata = ID_BASE + DW'(int'(addr) - OFS_ID_LO);
      default:    ;
    endcase
  end

  assign werr       = werr_q;
  assign sw_rst_req = req_q;
  assign boot_vec0  = LOCKING ? (boot0_q & VEC_MASK) : boot0_q;
  assign boot_vec1  = plain_q[PL_BOOT1];
  assign cpu_wait   = plain_q[PL_CPUWAIT];
  assign dbg_ctrl   = dbg_q;

  // ---------------- assertions ----------------
  // R11: error pulse only follows a bus write
  a_r11_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    werr |-> $past(wr_en));

  // R7: request only follows a write with bit 0 set
  a_r7_req_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_req |-> ($past(wr_en) && $past(wdata[0])));

  // R8: locked power control cannot change except by reset
  a_r8_pwr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_q[0] && warm_rst_n) |=> $stable(pwr_q));

  // R4: locked boot vector 0 holds on the locking variant
  a_r4_boot0_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (LOCKING && boot0_q[0] && warm_rst_n) |=> $stable(boot0_q));

  // R3: warm reset leaves the retention word alone
  a_r3_retain_warm: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm_rst_n && !wr_en) |=> $stable(plain_q[PL_RETAIN]));

  // R6: after a set write every written 1 is present
  a_r6_dbg_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && warm_rst_n && int'(addr) == OFS_DBGSET)
      |=> ((dbg_ctrl & $past(wdata)) == $past(wdata)));

endmodule

// File: tb/sim_sysctl_bank.sv
module sim_sysctl_bank;

  localparam int          DW       = 32;
  localparam int          AW       = 6;
  localparam logic [31:0] BOOT_RST = 32'h1000_0000;
  localparam logic [31:0] ID_BASE  = 32'h5C00_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rst_n, warm_rst_n, wr_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;

  logic [DW-1:0] b_rd [3];
  logic [DW-1:0] b_bv0 [3];
  logic [DW-1:0] b_bv1 [3];
  logic [DW-1:0] b_cw [3];
  logic [DW-1:0] b_dbg [3];
  logic          b_err [3];
  logic          b_req [3];

  for (genvar v = 0; v < 3; v++) begin : g_var
    sysctl_bank #(.DW(DW), .AW(AW), .VARIANT(v), .BOOT_RST(BOOT_RST),
                  .ID_BASE(ID_BASE), .VEC_LSB(7)) u0 (
      .clk (clk), .rst_n (rst_n), .warm_rst_n (warm_rst_n),
      .wr_en (wr_en), .addr (addr), .wdata (wdata),
      .rdata (b_rd[v]), .werr (b_err[v]), .sw_rst_req (b_req[v]),
      .boot_vec0 (b_bv0[v]), .boot_vec1 (b_bv1[v]),
      .cpu_wait (b_cw[v]), .dbg_ctrl (b_dbg[v])
    );
  end

  int checks = 0;
  int failures = 0;

  // ---------------- reference model ----------------
  logic [31:0] m [3][32];
  logic [31:0] m_dbg [3];
  logic        e_err [3];
  logic        e_req [3];

  // 0 unmapped, 1 storage, 2 read-only, 3 dbg set, 4 dbg clear,
  // 5 sw reset, 6 boot vector 0, 7 power control
  function automatic int kind(int v, int a);
    case (a)
      0, 1, 2, 5:   return 1;
      3:            return 6;
      4:            return (v < 2) ? 1 : 0;
      6:            return 3;
      7:            return 4;
      8:            return 5;
      9, 10, 11, 14: return (v >= 1) ? 1 : 0;
      12, 16:       return (v == 1) ? 1 : 0;
      13:           return (v == 2) ? 7 : 0;
      15:           return (v == 2) ? 1 : 0;
      17:           return (v == 1) ? 1 : ((v == 0) ? 2 : 0);
      18, 20, 21, 22, 23: return 2;
      default:      return 0;
    endcase
  endfunction

  function automatic logic [31:0] mread(int v, int a);
    int k = kind(v, a);
    if (k == 1 || k == 6 || k == 7) return m[v][a];
    if (a == 18) return m_dbg[v];
    if (a >= 20 && a <= 23) return ID_BASE + 32'(a - 20);
    return 32'h0;
  endfunction

  task automatic mreset(bit keep_retain);
    for (int v = 0; v < 3; v++) begin
      logic [31:0] r = m[v][2];
      for (int a = 0; a < 32; a++) m[v][a] = 32'h0;
      m[v][3]  = BOOT_RST;
      m[v][12] = BOOT_RST;
      m[v][13] = 32'h1;
      if (keep_retain) m[v][2] = r;
      m_dbg[v] = 32'h0;
      e_err[v] = 1'b0;
      e_req[v] = 1'b0;
    end
  endtask

  task automatic mwrite(int v, int a, logic [31:0] d);
    int k = kind(v, a);
    e_err[v] = 1'b0;
    e_req[v] = 1'b0;
    case (k)
      0, 2: e_err[v] = 1'b1;
      1:    m[v][a] = d;
      3:    m_dbg[v] = m_dbg[v] | d;
      4:    m_dbg[v] = m_dbg[v] & ~d;
      5:    e_req[v] = d[0];
      6:    if (v == 2 && m[v][3][0]) e_err[v] = 1'b1; else m[v][3] = d;
      7:    if (!m[v][13][0]) e_err[v] = 1'b1; else m[v][13] = d;
      default: ;
    endcase
  endtask

  task automatic chk(string tag, string what, int v, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s variant=%0d actual=%h expected=%h", tag, what, v, act, exp);
    end
  endtask

  task automatic compare(string tag, int a);
    for (int v = 0; v < 3; v++) begin
      chk(tag, "rdata", v, b_rd[v], mread(v, a));
      chk("R11", "werr", v, 32'(b_err[v]), 32'(e_err[v]));
      chk("R7", "sw_rst_req", v, 32'(b_req[v]), 32'(e_req[v]));
      chk("R5", "boot_vec0", v, b_bv0[v], (v == 2) ? (m[v][3] & 32'hFFFF_FF80) : m[v][3]);
      chk("R5", "boot_vec1", v, b_bv1[v], m[v][12]);
      chk("R9", "cpu_wait", v, b_cw[v], (v == 2) ? m[v][5] : m[v][4]);
      chk("R6", "dbg_ctrl", v, b_dbg[v], m_dbg[v]);
    end
  endtask

  // one bus cycle; inputs are driven just after a falling edge
  task automatic cyc(string tag, bit w, int a, logic [31:0] d);
    wr_en = w; addr = AW'(a); wdata = d; warm_rst_n = 1'b1;
    @(posedge clk);
    for (int v = 0; v < 3; v++) begin
      if (w) mwrite(v, a, d);
      else begin e_err[v] = 1'b0; e_req[v] = 1'b0; end
    end
    @(negedge clk);
    compare(tag, a);
  endtask

  task automatic rd(string tag, int a);
    cyc(tag, 1'b0, a, 32'h0);
  endtask

  task automatic warm(string tag, int a);
    wr_en = 1'b0; addr = AW'(a); warm_rst_n = 1'b0;
    @(posedge clk);
    mreset(1'b1);
    @(negedge clk);
    warm_rst_n = 1'b1;
    compare(tag, a);
  endtask

  task automatic power_on(string tag);
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; warm_rst_n = 1'b1;
    mreset(1'b0);
    @(negedge clk);
    compare(tag, 0);
    rst_n = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    for (int v = 0; v < 3; v++) for (int a = 0; a < 32; a++) m[v][a] = 32'h0;
    power_on("R12");
    for (int a = 0; a < 32; a++) rd("R12", a);

    // fill every offset with a distinct even pattern (no lock, no request)
    for (int a = 0; a < 32; a++) cyc("R1", 1'b1, a, (32'hA500_0000 ^ (32'(a) * 32'h0101_0100)) | 32'h1 & ((a == 13) ? 32'h1 : 32'h0));
    for (int a = 0; a < 32; a++) rd("R2", a);
    for (int a = 20; a <= 23; a++) rd("R10", a);

    // R9: CPU-wait locations
    cyc("R9", 1'b1, 4, 32'h0000_0011);
    cyc("R9", 1'b1, 5, 32'h0000_0022);
    rd("R9", 4);

    // R4 / R5: boot vector 0 lock
    cyc("R5", 1'b1, 3, 32'h2000_007E);
    cyc("R4", 1'b1, 3, 32'h1234_5681);
    cyc("R4", 1'b1, 3, 32'h0000_0000);
    cyc("R4", 1'b1, 3, 32'hFFFF_FFFE);
    rd("R4", 3);

    // R6: debug set/clear
    cyc("R6", 1'b1, 6, 32'h0000_F0F0);
    cyc("R6", 1'b1, 6, 32'h0000_0F00);
    cyc("R6", 1'b1, 7, 32'h0000_00F0);
    rd("R6", 18);
    rd("R6", 6);
    rd("R6", 7);
    cyc("R10", 1'b1, 18, 32'hFFFF_FFFF);
    rd("R10", 18);

    // R7: software reset request
    cyc("R7", 1'b1, 8, 32'hFFFF_FFFE);
    cyc("R7", 1'b1, 8, 32'h0000_0001);
    rd("R7", 8);
    cyc("R7", 1'b1, 8, 32'h8000_0001);
    cyc("R7", 1'b1, 8, 32'h0000_0001);
    rd("R7", 8);

    // R8: power control lock
    cyc("R8", 1'b1, 13, 32'h0000_00F1);
    cyc("R8", 1'b1, 13, 32'h0000_00A0);
    cyc("R8", 1'b1, 13, 32'h0000_0001);
    cyc("R8", 1'b1, 13, 32'h0000_0055);
    rd("R8", 13);

    // R10 / R11: refused writes, back to back and isolated
    cyc("R10", 1'b1, 19, 32'hDEAD_BEEF);
    cyc("R10", 1'b1, 31, 32'hDEAD_BEEF);
    rd("R11", 19);
    cyc("R10", 1'b1, 17, 32'h1357_9BDF);
    rd("R10", 17);
    cyc("R10", 1'b1, 21, 32'h0);
    rd("R10", 21);

    // R3: retention through warm reset, cleared by power-on
    cyc("R3", 1'b1, 2, 32'hCAFE_F00D);
    cyc("R3", 1'b1, 0, 32'h0000_0042);
    warm("R3", 2);
    rd("R12", 0);
    rd("R8", 13);
    rd("R4", 3);
    cyc("R8", 1'b1, 13, 32'h0000_0003);
    rd("R8", 13);
    power_on("R3");
    rd("R3", 2);

    // random traffic with occasional warm reset
    for (int i = 0; i < 1500; i++) begin
      int a = int'($urandom_range(0, 31));
      logic [31:0] d = $urandom;
      if (($urandom % 40) == 0) warm("R3", a);
      else if (($urandom % 6) == 0) rd("R2", a);
      else cyc("R1", 1'b1, a, d);
    end
    for (int a = 0; a < 32; a++) rd("R1", a);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule